// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a synchronous single-port SRAM core with a small internal array. Commands, addresses and byte enables are captured on the rising clock edge, and write data trails its address by the same number of cycles that read data takes to come back. Because of this, the shared data bus can carry a read word, then a write word, then a read word in consecutive cycles with no idle cycle between them.

A static mode input selects the timing. In flow-through mode, read data is driven in the cycle right after the address edge, and write data is sampled one edge after its address. In pipelined mode, read data passes through an output register and appears one cycle later, and write data is sampled two edges after its address. An on-chip 2-bit burst counter generates addresses for continue-burst cycles, in either linear or interleaved order. The core also provides per-byte write enables on 9-bit bytes, a clock enable that freezes all state, three chip selects, and an asynchronous output enable that gates the data drivers.

Top module: `lw_sram`

## Requirements
- R1: After reset no operation is pending and `dq_drv_o` is 0.
- R2: With `pipe_i`=0, a read sampled at edge k drives its word on `dq_o` with `dq_drv_o`=1 between edges k and k+1. A write sampled at edge k takes its data from `wdata_i` at edge k+1.
- R3: With `pipe_i`=1, a read sampled at edge k drives its word between edges k+1 and k+2. A write sampled at edge k takes its data at edge k+2.
- R4: Reads and writes may alternate on every enabled edge. A read that follows a write to the same address returns the new data, including while that write's data has not yet reached the array.
- R5: Byte b is bits [9b+8:9b]. A write updates byte b only when `ben_i[b]`=1. Bytes with `ben_i[b]`=0 keep their old value, and a bypassed read sees the same byte merge.
- R6: A begin cycle (`adv_i`=0) is an operation only when all three bits of `cs_i` are 1. Otherwise it is a deselect: nothing is read or written, and the burst ends. Continue cycles after a deselect do nothing.
- R7: A continue cycle (`adv_i`=1) repeats the operation type of the burst's begin cycle. With `ilv_i`=0, the low two address bits of the n-th continue are (start + n) mod 4, so the counter wraps back to the start after four continues. The upper bits are those of the start address.
- R8: With `ilv_i`=1, the low two address bits of the n-th continue are start XOR (n mod 4).
- R9: On an edge where `cke_i`=0, every input is ignored. Pending writes, burst state and the output word hold their values.
- R10: `oe_i`=0 forces `dq_drv_o` to 0 at once, without waiting for a clock edge, whatever the pipeline state.
- R11: `dq_drv_o` is 1 only in the data cycle of a read. It stays 0 in write data cycles and in idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable, active high |
| cs_i | input | 3 | Chip selects, all must be 1 to select |
| adv_i | input | 1 | 1 = continue burst, 0 = begin burst |
| we_i | input | 1 | 1 = write, 0 = read (begin cycles) |
| addr_i | input | ADDR_W | Word address |
| ben_i | input | BYTES | Byte write enables, active high |
| wdata_i | input | 9*BYTES | Late write data |
| pipe_i | input | 1 | Static: 1 = pipelined, 0 = flow-through |
| ilv_i | input | 1 | Static: 1 = interleaved burst, 0 = linear |
| oe_i | input | 1 | Asynchronous output enable, active high |
| dq_o | output | 9*BYTES | Read data (0 when not driven) |
| dq_drv_o | output | 1 | Output driver enable; 0 = high impedance |

## Verification
The bench runs both timing modes against one model of the array. Its sequences include:
- A read placed directly after a write to the same address, with partial byte enables. A core without the bypass comparator would return stale bytes in pipelined mode.
- Five-cycle bursts in both orders. These catch a counter that does not wrap or that uses the wrong order.
- Each chip select dropped on its own, followed by a readback. A select that is decoded wrongly would leave a stray write in the array.
- Clock-enable gaps while a late write is pending. If the core let any stage advance during such a gap, the write would commit the wrong data or the read word would shift.
- The output enable dropped in the middle of a cycle, which must turn the drivers off with no clock edge.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  localparam int unsigned BYTE_W = 9;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] n,
                                           input logic       ilv);
    return ilv ? (start ^ n) : (start + n);
  endfunction
endpackage

// File: rtl/lw_burst_gen.sv
module lw_burst_gen
  import lw_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic [2:0]        cs_i,
  input  logic              adv_i,
  input  logic              we_i,
  input  logic              ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              act_q, bwe_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_nx;
  logic              sel;

  assign sel    = &cs_i;
  assign cnt_nx = cnt_q + 2'd1;

  always_comb begin
    if (!adv_i) begin
      op_o   = sel ? (we_i ? OP_WR : OP_RD) : OP_NONE;
      addr_o = addr_i;
    end else begin
      op_o   = act_q ? (bwe_q ? OP_WR : OP_RD) : OP_NONE;
      addr_o = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nx, ilv_i)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      bwe_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (cke_i) begin
      if (!adv_i) begin
        act_q  <= sel;
        bwe_q  <= we_i;
        base_q <= addr_i;
        cnt_q  <= '0;
      end else if (act_q) begin
        cnt_q  <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/lw_ctrl_pipe.sv
module lw_ctrl_pipe
  import lw_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BYTES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTES-1:0]  ben_i,
  output op_e               s1_op_o,
  output logic [ADDR_W-1:0] s1_addr_o,
  output logic [BYTES-1:0]  s1_ben_o,
  output op_e               s2_op_o,
  output logic [ADDR_W-1:0] s2_addr_o,
  output logic [BYTES-1:0]  s2_ben_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_op_o   <= OP_NONE;
      s1_addr_o <= '0;
      s1_ben_o  <= '0;
      s2_op_o   <= OP_NONE;
      s2_addr_o <= '0;
      s2_ben_o  <= '0;
    end else if (cke_i) begin
      s1_op_o   <= op_i;
      s1_addr_o <= addr_i;
      s1_ben_o  <= ben_i;
      s2_op_o   <= s1_op_o;
      s2_addr_o <= s1_addr_o;
      s2_ben_o  <= s1_ben_o;
    end
  end
endmodule

// File: rtl/lw_array.sv
module lw_array
  import lw_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BYTES  = 2,
  localparam int unsigned DATA_W = BYTE_W * BYTES,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              pipe_i,
  input  op_e               d_op_i,
  input  logic [ADDR_W-1:0] d_addr_i,
  input  logic [BYTES-1:0]  d_ben_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] raw, merged, q_q;
  logic              wr_en, hit;

  assign wr_en = cke_i && (d_op_i == OP_WR);
  assign raw   = mem[rd_addr_i];
  // pending write whose data is on wdata_i this edge
  assign hit   = (d_op_i == OP_WR) && (d_addr_i == rd_addr_i);

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign merged[g*BYTE_W +: BYTE_W] = (hit && d_ben_i[g]) ?
        wdata_i[g*BYTE_W +: BYTE_W] : raw[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) begin
      for (int b = 0; b < BYTES; b++) begin
        if (d_ben_i[b]) mem[d_addr_i][b*BYTE_W +: BYTE_W] <= wdata_i[b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_q <= '0;
    else if (cke_i && pipe_i)   q_q <= merged;
  end

  assign q_o = pipe_i ? q_q : raw;
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BYTES  = 2,
  localparam int unsigned DATA_W = BYTE_W * BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic [2:0]        cs_i,
  input  logic              adv_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTES-1:0]  ben_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pipe_i,
  input  logic              ilv_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_drv_o
);
  op_e               c_op, s1_op, s2_op, d_op;
  logic [ADDR_W-1:0] c_addr, s1_addr, s2_addr, d_addr;
  logic [BYTES-1:0]  s1_ben, s2_ben, d_ben;
  logic [DATA_W-1:0] rd_q;

  lw_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i, .rst_ni, .cke_i, .cs_i, .adv_i, .we_i, .ilv_i, .addr_i,
    .op_o(c_op), .addr_o(c_addr)
  );

  lw_ctrl_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_pipe (
    .clk_i, .rst_ni, .cke_i,
    .op_i(c_op), .addr_i(c_addr), .ben_i,
    .s1_op_o(s1_op), .s1_addr_o(s1_addr), .s1_ben_o(s1_ben),
    .s2_op_o(s2_op), .s2_addr_o(s2_addr), .s2_ben_o(s2_ben)
  );

  // data phase: one stage late in flow-through, two in pipelined
  assign d_op   = pipe_i ? s2_op   : s1_op;
  assign d_addr = pipe_i ? s2_addr : s1_addr;
  assign d_ben  = pipe_i ? s2_ben  : s1_ben;

  lw_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_array (
    .clk_i, .rst_ni, .cke_i, .pipe_i,
    .d_op_i(d_op), .d_addr_i(d_addr), .d_ben_i(d_ben),
    .wdata_i, .rd_addr_i(s1_addr), .q_o(rd_q)
  );

  assign dq_drv_o = oe_i && (d_op == OP_RD);
  assign dq_o     = dq_drv_o ? rd_q : '0;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int unsigned DATA_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_i,
  input logic [2:0]        cs_i,
  input logic              adv_i,
  input logic              we_i,
  input logic              pipe_i,
  input logic              oe_i,
  input logic              dq_drv_o,
  input logic [DATA_W-1:0] rd_q
);
  logic beg_rd, beg_wr;
  assign beg_rd = cke_i && !adv_i && (&cs_i) && !we_i;
  assign beg_wr = cke_i && !adv_i && (&cs_i) && we_i;

  // R10
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !dq_drv_o);

  // R2
  ft_read_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_i && beg_rd) |=> (dq_drv_o == oe_i));

  // R3
  pl_read_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_i && beg_rd) ##1 cke_i |=> (dq_drv_o == oe_i));

  // R11
  ft_wr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_i && beg_wr) |=> !dq_drv_o);

  // R11
  pl_wr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_i && beg_wr) ##1 cke_i |=> !dq_drv_o);

  // R9
  cke_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> $stable(rd_q));
endmodule

bind lw_sram lw_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .cke_i, .cs_i, .adv_i, .we_i, .pipe_i, .oe_i,
  .dq_drv_o, .rd_q
);

// File: tb/lw_sram_tb.sv
module lw_sram_tb;
  localparam int CLK_P = 10;
  localparam int AW = 5;
  localparam int NB = 2;
  localparam int DW = 9 * NB;

  logic          clk_i = 1'b0, rst_ni = 1'b0, cke_i = 1'b1;
  logic [2:0]    cs_i = 3'b000;
  logic          adv_i = 1'b0, we_i = 1'b0, pipe_i = 1'b0, ilv_i = 1'b0, oe_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [NB-1:0] ben_i = '0;
  logic [DW-1:0] wdata_i = '0, dq_o;
  logic          dq_drv_o;

  lw_sram #(.ADDR_W(AW), .BYTES(NB)) u_dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [1<<AW];
  int            h_op [2];   // 0 none, 1 read, 2 write
  int            h_addr [2];
  logic [NB-1:0] h_ben [2];
  logic [DW-1:0] h_wd [2];
  bit            b_act, b_we;
  int            b_base, b_cnt;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 2; i++) begin
      h_op[i] = 0; h_addr[i] = 0; h_ben[i] = '0; h_wd[i] = '0;
    end
    b_act = 0; b_we = 0; b_base = 0; b_cnt = 0;
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic cyc(input bit cke, input logic [2:0] cs, input bit adv, input bit we,
                     input int addr, input logic [NB-1:0] ben, input bit oe, input string tag);
    int nop, naddr, dp, lo;
    logic [DW-1:0] nwd;
    bit exp_drv;
    cke_i = cke; cs_i = cs; adv_i = adv; we_i = we; addr_i = AW'(addr);
    ben_i = ben; oe_i = oe; wdata_i = DW'($urandom);
    nop = 0; naddr = addr; nwd = DW'($urandom);
    dp = pipe_i ? 1 : 0;
    if (cke) begin
      if (!adv) begin
        nop = (&cs) ? (we ? 2 : 1) : 0;
        b_act = &cs; b_we = we; b_base = addr; b_cnt = 0;
      end else if (b_act) begin
        b_cnt = (b_cnt + 1) % 4;
        lo = ilv_i ? ((b_base % 4) ^ b_cnt) : (((b_base % 4) + b_cnt) % 4);
        naddr = (b_base / 4) * 4 + lo;
        nop = b_we ? 2 : 1;
      end
      if (h_op[dp] == 2) wdata_i = h_wd[dp];
    end
    @(posedge clk_i);
    if (cke) begin
      if (h_op[dp] == 2)
        for (int b = 0; b < NB; b++)
          if (h_ben[dp][b]) ref_mem[h_addr[dp]][b*9 +: 9] = h_wd[dp][b*9 +: 9];
      h_op[1] = h_op[0]; h_addr[1] = h_addr[0]; h_ben[1] = h_ben[0]; h_wd[1] = h_wd[0];
      h_op[0] = nop; h_addr[0] = naddr; h_ben[0] = ben; h_wd[0] = nwd;
    end
    @(negedge clk_i);
    exp_drv = oe && (h_op[dp] == 1);
    chk(tag, DW'(dq_drv_o), DW'(exp_drv));
    if (exp_drv) chk(tag, dq_o, ref_mem[h_addr[dp]]);
  endtask

  task automatic do_reset(input bit pipe);
    @(negedge clk_i);
    rst_ni = 1'b0; pipe_i = pipe; cke_i = 1'b1; cs_i = 3'b000; adv_i = 1'b0; oe_i = 1'b1;
    repeat (2) @(negedge clk_i);
    clear_model();
    rst_ni = 1'b1;
    chk("R1", DW'(dq_drv_o), '0);
  endtask

  task automatic run_mode(input bit pipe);
    string lat;
    lat = pipe ? "R3" : "R2";
    do_reset(pipe);
    ilv_i = 1'b0;
    // fill and read back every address
    for (int a = 0; a < (1 << AW); a++) cyc(1, 3'b111, 0, 1, a, 2'b11, 1, "R11");
    for (int a = 0; a < (1 << AW); a++) cyc(1, 3'b111, 0, 0, a, 2'b00, 1, lat);
    // alternating write/read, same address, partial bytes
    for (int a = 0; a < 8; a++) begin
      cyc(1, 3'b111, 0, 1, a, 2'((a % 3) + 1), 1, "R5");
      cyc(1, 3'b111, 0, 0, a, 2'b00, 1, "R4");
    end
    // write, write, read to one address
    cyc(1, 3'b111, 0, 1, 9, 2'b01, 1, "R5");
    cyc(1, 3'b111, 0, 1, 9, 2'b10, 1, "R5");
    cyc(1, 3'b111, 0, 0, 9, 2'b00, 1, "R4");
    cyc(1, 3'b111, 0, 0, 9, 2'b00, 1, "R4");
    // bursts, linear then interleaved, five continues each
    for (int o = 0; o < 2; o++) begin
      ilv_i = o[0];
      cyc(1, 3'b111, 0, 1, 14, 2'b11, 1, o ? "R8" : "R7");
      for (int k = 0; k < 5; k++) cyc(1, 3'b000, 1, 0, 0, 2'b11, 1, o ? "R8" : "R7");
      cyc(1, 3'b111, 0, 0, 13, 2'b00, 1, o ? "R8" : "R7");
      for (int k = 0; k < 5; k++) cyc(1, 3'b000, 1, 1, 0, 2'b00, 1, o ? "R8" : "R7");
      for (int a = 12; a < 16; a++) cyc(1, 3'b111, 0, 0, a, 2'b00, 1, o ? "R8" : "R7");
    end
    ilv_i = 1'b0;
    // each chip select dropped alone
    for (int c = 0; c < 3; c++) begin
      cyc(1, 3'b111 & ~(3'b001 << c), 0, 1, 20 + c, 2'b11, 1, "R6");
      cyc(1, 3'b111 & ~(3'b001 << c), 0, 0, 20 + c, 2'b00, 1, "R6");
      cyc(1, 3'b000, 1, 0, 0, 2'b00, 1, "R6");
      cyc(1, 3'b111, 0, 0, 20 + c, 2'b00, 1, "R6");
      cyc(1, 3'b000, 0, 0, 0, 2'b00, 1, "R6");
      cyc(1, 3'b000, 0, 0, 0, 2'b00, 1, "R6");
    end
    // clock-enable gaps with a write pending and reads in flight
    cyc(1, 3'b111, 0, 1, 5, 2'b11, 1, "R9");
    cyc(0, 3'b111, 0, 0, 7, 2'b11, 1, "R9");
    cyc(0, 3'b111, 0, 1, 8, 2'b11, 1, "R9");
    cyc(1, 3'b111, 0, 0, 5, 2'b00, 1, "R9");
    cyc(0, 3'b111, 0, 1, 5, 2'b11, 1, "R9");
    cyc(1, 3'b111, 0, 0, 6, 2'b00, 1, "R9");
    cyc(0, 3'b000, 0, 0, 0, 2'b00, 1, "R9");
    cyc(1, 3'b111, 0, 0, 5, 2'b00, 1, "R9");
    cyc(1, 3'b000, 0, 0, 0, 2'b00, 1, "R9");
    cyc(1, 3'b000, 0, 0, 0, 2'b00, 1, "R9");
    // output enable: synchronous view and a mid-cycle drop
    cyc(1, 3'b111, 0, 0, 3, 2'b00, 0, "R10");
    cyc(1, 3'b111, 0, 0, 4, 2'b00, 0, "R10");
    cyc(1, 3'b111, 0, 0, 3, 2'b00, 1, "R10");
    cyc(1, 3'b111, 0, 0, 4, 2'b00, 1, "R10");
    if (dq_drv_o) begin
      oe_i = 1'b0; #1;
      chk("R10", DW'(dq_drv_o), '0);
    end else chk("R10", DW'(dq_drv_o), DW'(1));
    cyc(1, 3'b000, 0, 0, 0, 2'b00, 1, "R11");
    cyc(1, 3'b000, 0, 0, 0, 2'b00, 1, "R11");
    // mixed traffic sweep in both burst orders
    for (int o = 0; o < 2; o++) begin
      ilv_i = o[0];
      for (int i = 0; i < 300; i++)
        cyc(($urandom % 8) != 0, ($urandom % 6 == 0) ? 3'($urandom % 7) : 3'b111,
            ($urandom % 3) == 0, ($urandom % 2) == 1, int'($urandom % (1 << AW)),
            2'($urandom), ($urandom % 5) != 0, "R4");
    end
  endtask

  initial begin
    for (int a = 0; a < (1 << AW); a++) ref_mem[a] = '0;
    clear_model();
    run_mode(0);
    run_mode(1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule